// File: doc/BRIEF.md
# Clock Register Overlay Port

This block puts a byte-wide static-memory style port in front of a 2048 x 8 store. The store holds plain data, except for the eight highest addresses. Those addresses open onto a set of timekeeping registers. The host reads and writes them with the same cycles it uses for the store. The port is synchronous: every access is sampled on a rising edge of the system clock, and read data comes back one cycle later together with a drive-enable flag.

The timekeeping registers are visible copies that sit between the bus and a separate set of live BCD calendar counters. A one-second step comes from a prescaler that counts system clocks. A small state machine decides when the visible copies follow the counters, when they hold still, and when they are pushed back into the counters. The machine has five states:

- RUN: the visible copies track the counters after each step. RUN goes to WR_HOLD when the write-halt bit is set, and otherwise to RD_HOLD when the read-halt bit is set.
- RD_HOLD: the copies keep the snapshot taken when the read-halt bit was set. RD_HOLD goes to WR_HOLD when the write-halt bit is set, and to SYNC when the read-halt bit clears.
- WR_HOLD: the host loads new values. WR_HOLD goes to COMMIT when the write-halt bit clears.
- COMMIT: this state lasts one cycle and loads the copies into the counters. It then goes to WR_HOLD if the write-halt bit is set again, else to RD_HOLD if the read-halt bit is set, else to RUN.
- SYNC: this state lasts one cycle and copies the live counters into the visible registers. It then goes to RUN.

A power-fail input blocks every access, as if the port were not selected.

Top module: `rtc_sram_port`

## Requirements
- R1: Addresses 0x7F8 through 0x7FF select, in this order, control, seconds, minutes, hours, weekday, date, month and year. Every lower address is plain read/write storage.
- R2: An edge with sel_n=0 and write_en_n=0 writes wdata. An edge with sel_n=0, write_en_n=1 and read_en_n=0 is a read: in the following cycle rdata carries the byte and drive_en is 1. Any other combination writes nothing and leaves drive_en at 0 in the following cycle.
- R3: While pwr_fail is 1, no access takes place: nothing is written, and drive_en is 0 in the following cycle.
- R4: Control bit 7 is the write-halt bit and control bit 6 is the read-halt bit. Control bits 5:0 always read as 0.
- R5: While the read-halt bit is 1, the visible time holds the value it had when the bit was set, and the live counters keep counting.
- R6: When the read-halt bit returns to 0, the visible registers take the live counter values two cycles after the clearing write, which is well inside one second.
- R7: While the write-halt bit is 1, host writes land in the visible registers only. Clearing the bit loads them into the counters after two cycles and restarts the one-second prescaler, and counting continues from the loaded time.
- R8: With both halt bits clear, the visible registers take the counter values after every one-second step, so two reads one step apart differ by exactly one second.
- R9: The counters use 24-hour BCD. Seconds and minutes wrap at 59, hours at 23, the weekday counts 1 to 7 and then returns to 1. The date wraps after day 28 or 29 of month 02, after day 30 of months 04, 06, 09 and 11, and after day 31 of the other months. The month wraps from 12 to 01 and the year from 99 to 00. Years divisible by four are leap years.
- R10: Seconds bit 7 is the oscillator-stop bit. While it is 1, the counters and the visible time do not advance.
- R11: Weekday bit 6 is the frequency-test bit. While it is 1 and the oscillator runs, seconds bit 0 reads as a square wave that changes level every FT_DIV clocks.
- R12: Unused bits read back as 0 whatever was written. The readable masks are: control 0xC0, seconds 0xFF, minutes 0x7F, hours 0x3F, weekday 0x47, date 0x3F, month 0x1F, year 0xFF.
- R13: After reset, control reads 0x00 and the time reads 00:00:00, weekday 01, date 01, month 01, year 00, with the stop and test bits clear and drive_en at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; accesses are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select for the port |
| read_en_n | input | 1 | Active-low request for read data drive |
| write_en_n | input | 1 | Active-low write strobe |
| addr | input | 11 | Byte address |
| wdata | input | 8 | Write data |
| pwr_fail | input | 1 | Supply-fault flag; blocks all accesses while high |
| rdata | output | 8 | Read data, valid while drive_en is high, 0 otherwise |
| drive_en | output | 1 | High in the cycle after an accepted read |

## Verification
Read data and drive_en are due in the cycle after the edge that samples the read. The bench therefore drives on the falling edge and samples one nanosecond after the next rising edge. A cleared halt bit takes effect two cycles after its write: one cycle to change state, then the load or copy. The bench waits two cycles before it reads a refreshed value, and it places its snapshot writes between one-second steps by waiting a known number of clocks from the commit. Free-run and square-wave checks space their two reads exactly one step period, or FT_DIV clocks, apart, so exactly one change falls between them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] yr;
        logic [4:0] mon;
        logic [5:0] date;
        logic [2:0] dow;
        logic [5:0] hr;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    localparam rtc_time_t RTC_RESET_TIME = '{
        yr:   8'h00,
        mon:  5'h01,
        date: 6'h01,
        dow:  3'd1,
        hr:   6'h00,
        min:  7'h00,
        sec:  7'h00
    };

    typedef enum logic [2:0] {
        ST_RUN,
        ST_RD_HOLD,
        ST_WR_HOLD,
        ST_COMMIT,
        ST_SYNC
    } shadow_st_t;

    localparam logic [2:0] IDX_CTL  = 3'd0;
    localparam logic [2:0] IDX_SEC  = 3'd1;
    localparam logic [2:0] IDX_MIN  = 3'd2;
    localparam logic [2:0] IDX_HR   = 3'd3;
    localparam logic [2:0] IDX_DOW  = 3'd4;
    localparam logic [2:0] IDX_DATE = 3'd5;
    localparam logic [2:0] IDX_MON  = 3'd6;
    localparam logic [2:0] IDX_YR   = 3'd7;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = v + 8'd1;
        end
        return r;
    endfunction

    function automatic logic is_leap(input logic [7:0] yr);
        logic odd_tens;
        logic [3:0] ones;
        odd_tens = yr[4];
        ones     = yr[3:0];
        if (odd_tens) begin
            return (ones == 4'd2) || (ones == 4'd6);
        end
        return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    endfunction

    function automatic logic [5:0] last_date(input logic [4:0] mon, input logic [7:0] yr);
        logic [5:0] r;
        case (mon)
            5'h02:                      r = is_leap(yr) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction

    function automatic rtc_time_t time_step(input rtc_time_t t);
        rtc_time_t n;
        logic [7:0] tmp;
        n   = t;
        tmp = 8'h00;
        if (t.sec == 7'h59) begin
            n.sec = 7'h00;
            if (t.min == 7'h59) begin
                n.min = 7'h00;
                if (t.hr == 6'h23) begin
                    n.hr  = 6'h00;
                    n.dow = (t.dow == 3'd7) ? 3'd1 : t.dow + 3'd1;
                    if (t.date == last_date(t.mon, t.yr)) begin
                        n.date = 6'h01;
                        if (t.mon == 5'h12) begin
                            n.mon = 5'h01;
                            n.yr  = (t.yr == 8'h99) ? 8'h00 : bcd_inc(t.yr);
                        end else begin
                            tmp   = bcd_inc({3'b000, t.mon});
                            n.mon = tmp[4:0];
                        end
                    end else begin
                        tmp    = bcd_inc({2'b00, t.date});
                        n.date = tmp[5:0];
                    end
                end else begin
                    tmp  = bcd_inc({2'b00, t.hr});
                    n.hr = tmp[5:0];
                end
            end else begin
                tmp   = bcd_inc({1'b0, t.min});
                n.min = tmp[6:0];
            end
        end else begin
            tmp   = bcd_inc({1'b0, t.sec});
            n.sec = tmp[6:0];
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_store.sv
module rtc_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
#(
    parameter int TICK_DIV = 32768,
    parameter int FT_DIV   = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      osc_stop,
    input  logic      ft_en,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t live,
    output logic      stepped,
    output logic      ft_phase
);
    localparam int PW = $clog2(TICK_DIV + 1);
    localparam int FW = $clog2(FT_DIV + 1);
    localparam logic [PW-1:0] PSC_LAST = PW'(TICK_DIV - 1);
    localparam logic [FW-1:0] FT_LAST  = FW'(FT_DIV - 1);

    logic [PW-1:0] psc;
    logic [FW-1:0] ft_cnt;

    // live counters and one-second prescaler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc     <= '0;
            live    <= RTC_RESET_TIME;
            stepped <= 1'b0;
        end else begin
            stepped <= 1'b0;
            if (load) begin
                live <= load_val;
                psc  <= '0;
            end else if (!osc_stop) begin
                if (psc == PSC_LAST) begin
                    psc     <= '0;
                    live    <= time_step(live);
                    stepped <= 1'b1;
                end else begin
                    psc <= psc + 1'b1;
                end
            end
        end
    end

    // square wave for the frequency-test readback
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ft_cnt   <= '0;
            ft_phase <= 1'b0;
        end else if (ft_en && !osc_stop) begin
            if (ft_cnt == FT_LAST) begin
                ft_cnt   <= '0;
                ft_phase <= ~ft_phase;
            end else begin
                ft_cnt <= ft_cnt + 1'b1;
            end
        end else begin
            ft_cnt <= '0;
        end
    end

endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] idx,
    input  logic [7:0] wdata,
    input  rtc_time_t  live,
    input  logic       stepped,
    input  logic       ft_phase,
    output rtc_time_t  vis,
    output logic [7:0] rd_byte,
    output logic       load,
    output logic       osc_stop,
    output logic       ft_en,
    output shadow_st_t st
);
    shadow_st_t nxt;
    logic       ctl_w;
    logic       ctl_r;
    logic       copy_live;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_RUN;
        end else begin
            st <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_RUN: begin
                if (ctl_w) begin
                    nxt = ST_WR_HOLD;
                end else if (ctl_r) begin
                    nxt = ST_RD_HOLD;
                end
            end
            ST_RD_HOLD: begin
                if (ctl_w) begin
                    nxt = ST_WR_HOLD;
                end else if (!ctl_r) begin
                    nxt = ST_SYNC;
                end
            end
            ST_WR_HOLD: begin
                if (!ctl_w) begin
                    nxt = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                if (ctl_w) begin
                    nxt = ST_WR_HOLD;
                end else if (ctl_r) begin
                    nxt = ST_RD_HOLD;
                end else begin
                    nxt = ST_RUN;
                end
            end
            ST_SYNC: begin
                nxt = ST_RUN;
            end
            default: begin
                nxt = ST_RUN;
            end
        endcase
    end

    // state outputs
    always_comb begin
        copy_live = 1'b0;
        load      = 1'b0;
        unique case (st)
            ST_RUN:     copy_live = stepped && !ctl_w && !ctl_r;
            ST_RD_HOLD: copy_live = 1'b0;
            ST_WR_HOLD: copy_live = 1'b0;
            ST_COMMIT:  load      = 1'b1;
            ST_SYNC:    copy_live = 1'b1;
            default:    copy_live = 1'b0;
        endcase
    end

    // visible copies; a host write wins over a copy in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis      <= RTC_RESET_TIME;
            ctl_w    <= 1'b0;
            ctl_r    <= 1'b0;
            osc_stop <= 1'b0;
            ft_en    <= 1'b0;
        end else begin
            if (copy_live) begin
                vis <= live;
            end
            if (wr_en) begin
                unique case (idx)
                    IDX_CTL: begin
                        ctl_w <= wdata[7];
                        ctl_r <= wdata[6];
                    end
                    IDX_SEC: begin
                        osc_stop <= wdata[7];
                        vis.sec  <= wdata[6:0];
                    end
                    IDX_MIN:  vis.min <= wdata[6:0];
                    IDX_HR:   vis.hr  <= wdata[5:0];
                    IDX_DOW: begin
                        ft_en   <= wdata[6];
                        vis.dow <= wdata[2:0];
                    end
                    IDX_DATE: vis.date <= wdata[5:0];
                    IDX_MON:  vis.mon  <= wdata[4:0];
                    IDX_YR:   vis.yr   <= wdata;
                    default:  vis.yr   <= vis.yr;
                endcase
            end
        end
    end

    // readback with unused bits forced low
    always_comb begin
        rd_byte = 8'h00;
        unique case (idx)
            IDX_CTL:  rd_byte = {ctl_w, ctl_r, 6'b000000};
            IDX_SEC:  rd_byte = {osc_stop, vis.sec[6:1],
                                 (ft_en && !osc_stop) ? ft_phase : vis.sec[0]};
            IDX_MIN:  rd_byte = {1'b0, vis.min};
            IDX_HR:   rd_byte = {2'b00, vis.hr};
            IDX_DOW:  rd_byte = {1'b0, ft_en, 3'b000, vis.dow};
            IDX_DATE: rd_byte = {2'b00, vis.date};
            IDX_MON:  rd_byte = {3'b000, vis.mon};
            IDX_YR:   rd_byte = vis.yr;
            default:  rd_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_sram_port.sv
module rtc_sram_port
    import rtc_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int TICK_DIV = 32768,
    parameter int FT_DIV   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              read_en_n,
    input  logic              write_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              pwr_fail,
    output logic [7:0]        rdata,
    output logic              drive_en
);
    localparam int BYTE_W = 8;

    logic        access_ok;
    logic        bus_wr;
    logic        bus_rd;
    logic        in_clk;
    logic        ram_we;
    logic        ram_re;
    logic        clk_we;
    logic [BYTE_W-1:0] ram_q;
    logic [BYTE_W-1:0] clk_q;
    logic [BYTE_W-1:0] rd_byte;
    logic        sel_clk_q;
    logic        drv_q;

    rtc_time_t  vis;
    rtc_time_t  live;
    logic       stepped;
    logic       ft_phase;
    logic       load;
    logic       osc_stop;
    logic       ft_en;
    shadow_st_t st;

    assign access_ok = !sel_n && !pwr_fail;
    assign bus_wr    = access_ok && !write_en_n;
    assign bus_rd    = access_ok && write_en_n && !read_en_n;
    assign in_clk    = &addr[ADDR_W-1:3];
    assign ram_we    = bus_wr && !in_clk;
    assign ram_re    = bus_rd && !in_clk;
    assign clk_we    = bus_wr && in_clk;

    rtc_store #(
        .AW (ADDR_W),
        .DW (BYTE_W)
    ) u_store (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (addr),
        .wdata (wdata),
        .rdata (ram_q)
    );

    rtc_counter #(
        .TICK_DIV (TICK_DIV),
        .FT_DIV   (FT_DIV)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_stop (osc_stop),
        .ft_en    (ft_en),
        .load     (load),
        .load_val (vis),
        .live     (live),
        .stepped  (stepped),
        .ft_phase (ft_phase)
    );

    rtc_shadow u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (clk_we),
        .idx      (addr[2:0]),
        .wdata    (wdata),
        .live     (live),
        .stepped  (stepped),
        .ft_phase (ft_phase),
        .vis      (vis),
        .rd_byte  (rd_byte),
        .load     (load),
        .osc_stop (osc_stop),
        .ft_en    (ft_en),
        .st       (st)
    );

    // registered read path, one cycle after the sampling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q     <= 1'b0;
            sel_clk_q <= 1'b0;
            clk_q     <= '0;
        end else begin
            drv_q <= bus_rd;
            if (bus_rd) begin
                sel_clk_q <= in_clk;
                clk_q     <= rd_byte;
            end
        end
    end

    assign drive_en = drv_q;
    assign rdata    = drv_q ? (sel_clk_q ? clk_q : ram_q) : '0;

endmodule

// File: rtl/rtc_sram_port_chk.sv
module rtc_sram_port_chk
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              read_en_n,
    input logic              write_en_n,
    input logic [ADDR_W-1:0] addr,
    input logic              pwr_fail,
    input logic [7:0]        rdata,
    input logic              drive_en,
    input shadow_st_t        st,
    input logic              clk_we,
    input rtc_time_t         vis,
    input rtc_time_t         live,
    input logic              load,
    input logic              osc_stop
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = {{(ADDR_W-3){1'b1}}, 3'b000};

    // R2
    desel_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !drive_en);

    // R3
    pwr_fail_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !drive_en);

    // R4
    ctl_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && write_en_n && !read_en_n && !pwr_fail && addr == CTL_ADDR)
        |=> (drive_en && rdata[5:0] == 6'd0));

    // R5
    rd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD_HOLD && !clk_we) |=> $stable(vis));

    // R7
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R10
    osc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && !load) |=> $stable(live));

endmodule

bind rtc_sram_port rtc_sram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .read_en_n  (read_en_n),
    .write_en_n (write_en_n),
    .addr       (addr),
    .pwr_fail   (pwr_fail),
    .rdata      (rdata),
    .drive_en   (drive_en),
    .st         (st),
    .clk_we     (clk_we),
    .vis        (vis),
    .live       (live),
    .load       (load),
    .osc_stop   (osc_stop)
);

// File: tb/rtc_sram_port_bench.sv
`timescale 1ns/1ps
module rtc_sram_port_bench;
    localparam int TICK = 20;
    localparam int FT   = 4;

    localparam logic [10:0] A_CTL  = 11'h7F8;
    localparam logic [10:0] A_SEC  = 11'h7F9;
    localparam logic [10:0] A_MIN  = 11'h7FA;
    localparam logic [10:0] A_HR   = 11'h7FB;
    localparam logic [10:0] A_DOW  = 11'h7FC;
    localparam logic [10:0] A_DATE = 11'h7FD;
    localparam logic [10:0] A_MON  = 11'h7FE;
    localparam logic [10:0] A_YR   = 11'h7FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        read_en_n = 1'b1;
    logic        write_en_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        pwr_fail = 1'b0;
    logic [7:0]  rdata;
    logic        drive_en;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rtc_sram_port #(
        .ADDR_W   (11),
        .TICK_DIV (TICK),
        .FT_DIV   (FT)
    ) u_rtc_sram_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .read_en_n  (read_en_n),
        .write_en_n (write_en_n),
        .addr       (addr),
        .wdata      (wdata),
        .pwr_fail   (pwr_fail),
        .rdata      (rdata),
        .drive_en   (drive_en)
    );

    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_ok(input string req, input logic ok, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (ok !== 1'b1) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic [10:0] a, input logic [7:0] d, input logic s,
                         input logic o, input logic w, input logic p,
                         output logic [7:0] q, output logic de);
        @(negedge clk);
        sel_n = s; read_en_n = o; write_en_n = w; pwr_fail = p; addr = a; wdata = d;
        @(posedge clk);
        #1;
        q = rdata;
        de = drive_en;
        sel_n = 1'b1; read_en_n = 1'b1; write_en_n = 1'b1; pwr_fail = 1'b0;
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        logic [7:0] q;
        logic de;
        cycle(a, d, 1'b0, 1'b1, 1'b0, 1'b0, q, de);
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] q);
        logic de;
        cycle(a, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, q, de);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic load_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                             input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                             input logic [7:0] y);
        wr(A_CTL, 8'h80);
        wr(A_SEC, s); wr(A_MIN, m); wr(A_HR, h); wr(A_DOW, dw);
        wr(A_DATE, dt); wr(A_MON, mo); wr(A_YR, y);
        wr(A_CTL, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] q;
        check("R13 drive_en idle", {7'd0, drive_en}, 8'h00);
        rd(A_CTL, q);  check("R13 control", q, 8'h00);
        rd(A_SEC, q);  check("R13 seconds", q, 8'h00);
        rd(A_HR, q);   check("R13 hours", q, 8'h00);
        rd(A_DOW, q);  check("R13 weekday", q, 8'h01);
        rd(A_DATE, q); check("R13 date", q, 8'h01);
        rd(A_MON, q);  check("R13 month", q, 8'h01);
        rd(A_YR, q);   check("R13 year", q, 8'h00);
    endtask

    task automatic t_ram();
        logic [7:0] q;
        logic de;
        wr(11'h000, 8'hA5);
        wr(11'h7F7, 8'h3C);
        wr(11'h123, 8'h5A);
        rd(11'h000, q); check("R1 ram low", q, 8'hA5);
        rd(11'h7F7, q); check("R1 ram top", q, 8'h3C);
        cycle(11'h123, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, q, de);
        check("R2 read data", q, 8'h5A);
        check("R2 read drive", {7'd0, de}, 8'h01);
    endtask

    task automatic t_select();
        logic [7:0] q;
        logic de;
        cycle(11'h123, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, q, de);
        rd(11'h123, q); check("R2 deselected write ignored", q, 8'h5A);
        cycle(11'h123, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, q, de);
        check("R2 output disabled no drive", {7'd0, de}, 8'h00);
        cycle(11'h123, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, q, de);
        check("R2 deselected no drive", {7'd0, de}, 8'h00);
    endtask

    task automatic t_pwr();
        logic [7:0] q;
        logic de;
        cycle(11'h123, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1, q, de);
        rd(11'h123, q); check("R3 write blocked", q, 8'h5A);
        cycle(11'h123, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, q, de);
        check("R3 read blocked", {7'd0, de}, 8'h00);
    endtask

    task automatic t_ctl_mask();
        logic [7:0] q;
        wr(A_CTL, 8'h3F);
        rd(A_CTL, q); check("R4 control low bits", q, 8'h00);
    endtask

    task automatic t_set_leap();
        logic [7:0] q;
        wr(A_CTL, 8'h80);
        rd(A_CTL, q);  check("R4 write-halt bit", q, 8'h80);
        wr(A_MON, 8'hFF);  rd(A_MON, q);  check("R12 month mask", q, 8'h1F);
        wr(A_HR, 8'hFF);   rd(A_HR, q);   check("R12 hours mask", q, 8'h3F);
        wr(A_MIN, 8'hFF);  rd(A_MIN, q);  check("R12 minutes mask", q, 8'h7F);
        wr(A_DATE, 8'hFF); rd(A_DATE, q); check("R12 date mask", q, 8'h3F);
        wr(A_DOW, 8'hBF);  rd(A_DOW, q);  check("R12 weekday mask", q, 8'h07);
        load_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24);
        idle(45);
        wr(A_CTL, 8'h40);
        rd(A_CTL, q);  check("R4 read-halt bit", q, 8'h40);
        rd(A_SEC, q);  check("R7 seconds after commit", q, 8'h00);
        rd(A_MIN, q);  check("R9 minutes wrap", q, 8'h00);
        rd(A_HR, q);   check("R9 hours wrap", q, 8'h00);
        rd(A_DOW, q);  check("R9 weekday wrap", q, 8'h01);
        rd(A_DATE, q); check("R9 leap date", q, 8'h29);
        rd(A_MON, q);  check("R9 leap month", q, 8'h02);
        rd(A_YR, q);   check("R7 year kept", q, 8'h24);
    endtask

    task automatic t_read_halt();
        logic [7:0] a;
        logic [7:0] b;
        rd(A_SEC, a);
        idle(50);
        rd(A_SEC, b); check("R5 frozen seconds", b, a);
        wr(A_CTL, 8'h00);
        idle(2);
        rd(A_SEC, b);
        check_ok("R6 refreshed seconds", (b != a) && (b <= 8'h03), b, 8'h02);
    endtask

    task automatic snap_after_one(output logic [7:0] dt, output logic [7:0] mo,
                                  output logic [7:0] y, output logic [7:0] dw);
        idle(25);
        wr(A_CTL, 8'h40);
        rd(A_DATE, dt);
        rd(A_MON, mo);
        rd(A_YR, y);
        rd(A_DOW, dw);
    endtask

    task automatic t_rollover();
        logic [7:0] dt;
        logic [7:0] mo;
        logic [7:0] y;
        logic [7:0] dw;
        load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        snap_after_one(dt, mo, y, dw);
        check("R9 non-leap date", dt, 8'h01);
        check("R9 non-leap month", mo, 8'h03);
        check("R9 weekday step", dw, 8'h04);
        load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h31);
        snap_after_one(dt, mo, y, dw);
        check("R9 thirty-day date", dt, 8'h01);
        check("R9 thirty-day month", mo, 8'h05);
        load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        snap_after_one(dt, mo, y, dw);
        check("R9 year wrap", y, 8'h00);
        check("R9 month wrap", mo, 8'h01);
        check("R9 new-year date", dt, 8'h01);
    endtask

    task automatic t_free_run();
        logic [7:0] a;
        logic [7:0] b;
        wr(A_CTL, 8'h00);
        idle(2);
        rd(A_SEC, a);
        idle(TICK - 1);
        rd(A_SEC, b);
        check("R8 one-second step", b, bcd_next(a));
    endtask

    task automatic t_osc();
        logic [7:0] s1;
        logic [7:0] s2;
        logic [7:0] s3;
        wr(A_SEC, 8'h80);
        idle(2);
        rd(A_SEC, s1);
        idle(50);
        rd(A_SEC, s2);
        check("R10 stopped seconds", s2, s1);
        check("R10 stop bit reads", {7'd0, s2[7]}, 8'h01);
        wr(A_SEC, 8'h00);
        idle(45);
        rd(A_SEC, s3);
        check_ok("R10 restart advances", (s3[7] == 1'b0) && (s3[6:0] != s2[6:0]), s3, s2);
    endtask

    task automatic t_ft();
        logic [7:0] a;
        logic [7:0] b;
        wr(A_DOW, 8'h41);
        idle(2);
        rd(A_SEC, a);
        idle(FT - 1);
        rd(A_SEC, b);
        check("R11 test wave toggles", {7'd0, b[0]}, {7'd0, ~a[0]});
        rd(A_DOW, a);
        check_ok("R11 test bit reads", a[6] == 1'b1, a, 8'h41);
        wr(A_DOW, 8'h01);
        rd(A_DOW, a);
        check_ok("R11 test bit cleared", a[6] == 1'b0, a, 8'h01);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_ram();
        t_select();
        t_pwr();
        t_ctl_mask();
        t_set_leap();
        t_read_halt();
        t_rollover();
        t_free_run();
        t_osc();
        t_ft();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule